// File: doc/BRIEF.md
# Host Request Dispatch Scheduler

This block sits between the host command queue of a compute-capable storage controller and the engines that carry out each request. Host requests enter a small internal queue. They leave it one at a time, in arrival order. A two-bit kind field picks the route. Plain reads and writes go to the conventional I/O handler. Computational requests go to a dispatch path that targets one of several storage processors over a ring.

A computational write goes through three steps. First the block starts a transfer that moves the request payload from host memory into a local buffer. It waits for that transfer to finish, then waits until the target processor holds at least one credit. It then sends the request over the ring and waits for the processor to acknowledge it. A computational read runs in the other direction. The block dispatches it over the ring first, and after the acknowledgement it moves the result from the local buffer out to host memory.

Every request carries a tag. When a request completes, the status bit for its tag is set. An interrupt stays raised while any status bit is set. Software reads the status vector and clears bits one tag at a time. The transfer engine, the ring and the I/O handler all sit outside this block and are reached through handshake ports.

Top module: `req_dispatch_sched`

## Requirements
- R1: A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low exactly when FIFO_DEPTH accepted requests are still waiting in the queue.
- R2: Kind 2'b00 is an I/O read and kind 2'b01 is an I/O write. Both go to the I/O port. `io_valid` stays high, with stable fields, until `io_ready` is seen. `io_write` equals bit 0 of the kind.
- R3: Kind 2'b10 is a compute write. It first raises `dma_start` for exactly one cycle with `dma_to_host` low. The block then waits for `dma_done` and issues nothing else until it arrives.
- R4: A compute request is sent over the ring only while its target processor's credit count is non-zero. `ring_valid` is a one-cycle pulse. With no credit, the request waits.
- R5: Each processor's credit count starts at CREDITS after reset. It drops by one on each dispatch to that processor and rises by one on each cycle its `credit_ret` bit is high.
- R6: For a compute write, the `ring_ack` that follows the dispatch sets `tag_status[tag]` one cycle later.
- R7: Kind 2'b11 is a compute read. It is dispatched first, credit-gated, with `ring_read` high. After `ring_ack`, the block pulses `dma_start` with `dma_to_host` high, and `dma_done` then sets the tag's status bit.
- R8: `clr_valid` clears `tag_status[clr_tag]` one cycle later. If a set of the same tag happens in the same cycle, the set wins.
- R9: `irq` is high exactly when some `tag_status` bit is set.
- R10: Requests are served strictly in queue order, with only one active at a time. A compute request waiting for credit holds back every request behind it, including I/O requests. At most one of `io_valid`, `dma_start` and `ring_valid` is high in any cycle.
- R11: After a synchronous reset, `io_valid`, `dma_start`, `ring_valid`, `tag_status` and `irq` are all low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Queue has room |
| req_kind | input | 2 | 00 I/O read, 01 I/O write, 10 compute write, 11 compute read |
| req_sp | input | SP_W | Target storage processor |
| req_tag | input | TAG_W | Request tag |
| req_addr | input | ADDR_W | Command/data location |
| req_cmd | input | CMD_W | Application command word |
| io_valid | output | 1 | Request presented to I/O handler |
| io_ready | input | 1 | I/O handler takes request |
| io_write | output | 1 | I/O request is a write |
| io_addr | output | ADDR_W | I/O address |
| io_tag | output | TAG_W | I/O tag |
| dma_start | output | 1 | One-cycle transfer start |
| dma_to_host | output | 1 | 1: local buffer to host, 0: host to local buffer |
| dma_addr | output | ADDR_W | Transfer address |
| dma_tag | output | TAG_W | Transfer tag |
| dma_done | input | 1 | Transfer finished |
| ring_valid | output | 1 | One-cycle dispatch onto the ring |
| ring_read | output | 1 | Dispatch is a compute read |
| ring_sp | output | SP_W | Dispatch target |
| ring_addr | output | ADDR_W | Command location |
| ring_cmd | output | CMD_W | Command word |
| ring_tag | output | TAG_W | Dispatch tag |
| ring_ack | input | 1 | Target acknowledges dispatch |
| credit_ret | input | NUM_SP | Per-processor credit return pulses |
| clr_valid | input | 1 | Software clear strobe |
| clr_tag | input | TAG_W | Tag to clear |
| tag_status | output | NUM_TAGS | Completion bit per tag |
| irq | output | 1 | Completion interrupt |

## Verification
The bench drains one processor's credits with returns switched off and queues an I/O read behind the stalled request. A design that skipped the credit check would dispatch a third time. A design that let later work pass would issue the I/O read early. It fills the queue while the I/O handler refuses requests, so a wrong full flag would either drop a request or stall one slot too early. It holds a clear on a tag while that same tag completes. If clear beat set, the completion would vanish without ever being seen. It also mixes reads and writes to check the transfer direction and the order of transfer and dispatch, which a design with swapped compute-read steps would get wrong.

// File: rtl/rds_pkg.sv
package rds_pkg;
  typedef enum logic [1:0] {
    KIND_IO_RD = 2'b00,
    KIND_IO_WR = 2'b01,
    KIND_C_WR  = 2'b10,
    KIND_C_RD  = 2'b11
  } kind_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_IO   = 3'd1,
    ST_XFER = 3'd2,
    ST_SEND = 3'd3,
    ST_ACK  = 3'd4
  } state_t;
endpackage

// File: rtl/rq_fifo.sv
module rq_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/credit_bank.sv
module credit_bank #(
  parameter int NUM_SP = 4,
  parameter int CREDITS = 2,
  localparam int SP_W = (NUM_SP > 1) ? $clog2(NUM_SP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [SP_W-1:0]   take_sp,
  input  logic [NUM_SP-1:0] ret,
  output logic [NUM_SP-1:0] avail
);
  localparam int CW = $clog2(CREDITS + 2);

  for (genvar s = 0; s < NUM_SP; s++) begin : g_sp
    logic [CW-1:0] cnt;
    logic          dec;
    assign dec = take && (take_sp == SP_W'(s));
    always_ff @(posedge clk) begin
      if (rst) cnt <= CW'(CREDITS);
      else if (ret[s] && !dec) cnt <= cnt + 1'b1;
      else if (dec && !ret[s]) cnt <= cnt - 1'b1;
    end
    assign avail[s] = (cnt != '0);
  end
endmodule

// File: rtl/tag_status.sv
module tag_status #(
  parameter int TAG_W = 3,
  localparam int NUM_TAGS = 1 << TAG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_valid,
  input  logic [TAG_W-1:0]    set_tag,
  input  logic                clr_valid,
  input  logic [TAG_W-1:0]    clr_tag,
  output logic [NUM_TAGS-1:0] status,
  output logic                irq
);
  logic [NUM_TAGS-1:0] status_n;

  always_comb begin
    status_n = status;
    if (clr_valid) status_n[clr_tag] = 1'b0;
    if (set_valid) status_n[set_tag] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_n;
      irq    <= |status_n;
    end
  end
endmodule

// File: rtl/req_dispatch_sched.sv
module req_dispatch_sched #(
  parameter int NUM_SP = 4,
  parameter int TAG_W = 3,
  parameter int ADDR_W = 16,
  parameter int CMD_W = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CREDITS = 2,
  localparam int SP_W = (NUM_SP > 1) ? $clog2(NUM_SP) : 1,
  localparam int NUM_TAGS = 1 << TAG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [SP_W-1:0]     req_sp,
  input  logic [TAG_W-1:0]    req_tag,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [CMD_W-1:0]    req_cmd,
  output logic                io_valid,
  input  logic                io_ready,
  output logic                io_write,
  output logic [ADDR_W-1:0]   io_addr,
  output logic [TAG_W-1:0]    io_tag,
  output logic                dma_start,
  output logic                dma_to_host,
  output logic [ADDR_W-1:0]   dma_addr,
  output logic [TAG_W-1:0]    dma_tag,
  input  logic                dma_done,
  output logic                ring_valid,
  output logic                ring_read,
  output logic [SP_W-1:0]     ring_sp,
  output logic [ADDR_W-1:0]   ring_addr,
  output logic [CMD_W-1:0]    ring_cmd,
  output logic [TAG_W-1:0]    ring_tag,
  input  logic                ring_ack,
  input  logic [NUM_SP-1:0]   credit_ret,
  input  logic                clr_valid,
  input  logic [TAG_W-1:0]    clr_tag,
  output logic [NUM_TAGS-1:0] tag_status,
  output logic                irq
);
  import rds_pkg::*;

  localparam int ENT_W = 2 + SP_W + TAG_W + ADDR_W + CMD_W;

  logic             fifo_full, fifo_empty, fifo_pop;
  logic [ENT_W-1:0] fifo_dout;
  kind_t            h_kind;
  logic [SP_W-1:0]  h_sp;
  logic [TAG_W-1:0] h_tag;
  logic [ADDR_W-1:0] h_addr;
  logic [CMD_W-1:0] h_cmd;

  state_t            state;
  kind_t             cur_kind;
  logic [SP_W-1:0]   cur_sp;
  logic [TAG_W-1:0]  cur_tag;
  logic [ADDR_W-1:0] cur_addr;
  logic [CMD_W-1:0]  cur_cmd;

  logic [NUM_SP-1:0] sp_avail;
  logic              take;
  logic              set_valid;

  assign req_ready = !fifo_full;

  rq_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (req_valid && !fifo_full),
    .din   ({req_kind, req_sp, req_tag, req_addr, req_cmd}),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  assign h_kind = kind_t'(fifo_dout[ENT_W-1 -: 2]);
  assign {h_sp, h_tag, h_addr, h_cmd} = fifo_dout[ENT_W-3:0];

  assign fifo_pop  = (state == ST_IDLE) && !fifo_empty;
  assign take      = (state == ST_SEND) && sp_avail[cur_sp];
  assign set_valid = ((state == ST_XFER) && dma_done && (cur_kind == KIND_C_RD)) ||
                     ((state == ST_ACK) && ring_ack && (cur_kind == KIND_C_WR));

  credit_bank #(.NUM_SP(NUM_SP), .CREDITS(CREDITS)) u_credit (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .take_sp (cur_sp),
    .ret     (credit_ret),
    .avail   (sp_avail)
  );

  tag_status #(.TAG_W(TAG_W)) u_status (
    .clk       (clk),
    .rst       (rst),
    .set_valid (set_valid),
    .set_tag   (cur_tag),
    .clr_valid (clr_valid),
    .clr_tag   (clr_tag),
    .status    (tag_status),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      io_valid   <= 1'b0;
      dma_start  <= 1'b0;
      ring_valid <= 1'b0;
      cur_kind   <= KIND_IO_RD;
      cur_sp     <= '0;
      cur_tag    <= '0;
      cur_addr   <= '0;
      cur_cmd    <= '0;
    end else begin
      dma_start  <= 1'b0;
      ring_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!fifo_empty) begin
            cur_kind <= h_kind;
            cur_sp   <= h_sp;
            cur_tag  <= h_tag;
            cur_addr <= h_addr;
            cur_cmd  <= h_cmd;
            case (h_kind)
              KIND_C_WR: begin
                dma_start <= 1'b1;
                state     <= ST_XFER;
              end
              KIND_C_RD: state <= ST_SEND;
              default: begin
                io_valid <= 1'b1;
                state    <= ST_IO;
              end
            endcase
          end
        end
        ST_IO: begin
          if (io_ready) begin
            io_valid <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        ST_XFER: begin
          if (dma_done) state <= (cur_kind == KIND_C_WR) ? ST_SEND : ST_IDLE;
        end
        ST_SEND: begin
          if (sp_avail[cur_sp]) begin
            ring_valid <= 1'b1;
            state      <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (ring_ack) begin
            if (cur_kind == KIND_C_WR) begin
              state <= ST_IDLE;
            end else begin
              dma_start <= 1'b1;
              state     <= ST_XFER;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign io_write    = cur_kind[0];
  assign io_addr     = cur_addr;
  assign io_tag      = cur_tag;
  assign dma_to_host = (cur_kind == KIND_C_RD);
  assign dma_addr    = cur_addr;
  assign dma_tag     = cur_tag;
  assign ring_read   = (cur_kind == KIND_C_RD);
  assign ring_sp     = cur_sp;
  assign ring_addr   = cur_addr;
  assign ring_cmd    = cur_cmd;
  assign ring_tag    = cur_tag;
endmodule

// File: rtl/rds_checker.sv
module rds_checker #(
  parameter int NUM_SP = 4,
  parameter int TAG_W = 3,
  parameter int CREDITS = 2,
  localparam int SP_W = (NUM_SP > 1) ? $clog2(NUM_SP) : 1,
  localparam int NUM_TAGS = 1 << TAG_W
) (
  input logic                clk,
  input logic                rst,
  input logic                io_valid,
  input logic                io_ready,
  input logic [TAG_W-1:0]    io_tag,
  input logic                dma_start,
  input logic                ring_valid,
  input logic [SP_W-1:0]     ring_sp,
  input logic [NUM_SP-1:0]   credit_ret,
  input logic [NUM_TAGS-1:0] tag_status,
  input logic                irq
);
  localparam int CW = $clog2(CREDITS + 3);

  logic [CW-1:0] seen_cnt [NUM_SP];

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SP; s++) begin
      if (rst) seen_cnt[s] <= CW'(CREDITS);
      else seen_cnt[s] <= seen_cnt[s] + CW'(credit_ret[s])
                          - CW'(ring_valid && (ring_sp == SP_W'(s)));
    end
  end

  AST_IO_HELD: assert property (@(posedge clk) disable iff (rst)
    io_valid && !io_ready |=> io_valid && $stable(io_tag)); // R2
  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
    dma_start |=> !dma_start); // R3
  AST_RING_PULSE: assert property (@(posedge clk) disable iff (rst)
    ring_valid |=> !ring_valid); // R4
  AST_CREDIT_HELD: assert property (@(posedge clk) disable iff (rst)
    ring_valid |-> seen_cnt[ring_sp] != '0); // R5
  AST_IRQ_ANY: assert property (@(posedge clk) disable iff (rst)
    irq == (tag_status != '0)); // R9
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({io_valid, dma_start, ring_valid})); // R10
endmodule

bind req_dispatch_sched rds_checker #(
  .NUM_SP(NUM_SP), .TAG_W(TAG_W), .CREDITS(CREDITS)
) chk_i (
  .clk(clk), .rst(rst), .io_valid(io_valid), .io_ready(io_ready),
  .io_tag(io_tag), .dma_start(dma_start), .ring_valid(ring_valid),
  .ring_sp(ring_sp), .credit_ret(credit_ret), .tag_status(tag_status),
  .irq(irq)
);

// File: tb/req_dispatch_sched_tb_top.sv
module req_dispatch_sched_tb_top;
  localparam int NUM_SP = 4;
  localparam int TAG_W = 3;
  localparam int ADDR_W = 16;
  localparam int CMD_W = 32;
  localparam int DEPTH = 4;
  localparam int CREDITS = 2;
  localparam int SP_W = 2;
  localparam int NT = 8;
  localparam int DMA_LAT = 3;
  localparam int ACK_LAT = 2;

  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [1:0] req_kind = 0;
  logic [SP_W-1:0] req_sp = 0;
  logic [TAG_W-1:0] req_tag = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [CMD_W-1:0] req_cmd = 0;
  logic io_valid, io_ready = 0, io_write;
  logic [ADDR_W-1:0] io_addr;
  logic [TAG_W-1:0] io_tag;
  logic dma_start, dma_to_host, dma_done = 0;
  logic [ADDR_W-1:0] dma_addr;
  logic [TAG_W-1:0] dma_tag;
  logic ring_valid, ring_read, ring_ack = 0;
  logic [SP_W-1:0] ring_sp;
  logic [ADDR_W-1:0] ring_addr;
  logic [CMD_W-1:0] ring_cmd;
  logic [TAG_W-1:0] ring_tag;
  logic [NUM_SP-1:0] credit_ret, credit_auto = 0, credit_man = 0;
  logic clr_valid = 0;
  logic [TAG_W-1:0] clr_tag = 0;
  logic [NT-1:0] tag_status;
  logic irq;

  assign credit_ret = credit_auto | credit_man;

  req_dispatch_sched #(.NUM_SP(NUM_SP), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
    .CMD_W(CMD_W), .FIFO_DEPTH(DEPTH), .CREDITS(CREDITS)) dut_i (.*);

  int total = 0, bad = 0, cyc = 0;
  bit chk_on = 0, finished = 0;
  bit io_gate = 1, auto_cr = 1, seen5 = 0;

  typedef struct { int kind; int sp; int tag; } mreq_t;
  mreq_t mq[$];
  mreq_t cur;
  int m_ph = 0;
  bit m_io = 0, m_dma = 0, m_ring = 0, m_dir = 0;
  int m_cr[NUM_SP];
  bit [NT-1:0] m_st = 0;
  int nb, disp, set_t;
  bit rdy;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_ph = 0; m_io = 0; m_dma = 0; m_ring = 0; m_st = 0;
      for (int s = 0; s < NUM_SP; s++) m_cr[s] = CREDITS;
    end else begin
      nb = mq.size(); rdy = (nb < DEPTH); disp = -1; set_t = -1;
      m_dma = 0; m_ring = 0;
      case (m_ph)
        0: if (nb > 0) begin
             cur = mq.pop_front();
             if (cur.kind < 2) begin m_io = 1; m_ph = 1; end
             else if (cur.kind == 2) begin m_dma = 1; m_dir = 0; m_ph = 2; end
             else m_ph = 3;
           end
        1: if (io_ready) begin m_io = 0; m_ph = 0; end
        2: if (dma_done) begin
             if (cur.kind == 2) m_ph = 3; else begin set_t = cur.tag; m_ph = 0; end
           end
        3: if (m_cr[cur.sp] > 0) begin m_ring = 1; disp = cur.sp; m_ph = 4; end
        4: if (ring_ack) begin
             if (cur.kind == 2) begin set_t = cur.tag; m_ph = 0; end
             else begin m_dma = 1; m_dir = 1; m_ph = 2; end
           end
        default: m_ph = 0;
      endcase
      for (int s = 0; s < NUM_SP; s++) m_cr[s] = m_cr[s] + int'(credit_ret[s]) - ((disp == s) ? 1 : 0);
      if (clr_valid) m_st[clr_tag] = 0;
      if (set_t >= 0) m_st[set_t] = 1;
      if (req_valid && rdy) mq.push_back('{int'(req_kind), int'(req_sp), int'(req_tag)});
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    cyc++;
    if (chk_on) begin
      chk(req_ready == (mq.size() < DEPTH), "R1", "req_ready", req_ready, mq.size() < DEPTH);
      chk(io_valid == m_io, "R2", "io_valid", io_valid, m_io);
      if (m_io) begin
        chk(io_write == cur.kind[0], "R2", "io_write", io_write, cur.kind[0]);
        chk(io_tag == TAG_W'(cur.tag), "R10", "io_tag order", io_tag, cur.tag);
      end
      chk(dma_start == m_dma, "R3", "dma_start", dma_start, m_dma);
      if (m_dma) chk(dma_to_host == m_dir, "R7", "dma_to_host", dma_to_host, m_dir);
      chk(ring_valid == m_ring, "R4", "ring_valid", ring_valid, m_ring);
      if (m_ring) begin
        chk(ring_sp == SP_W'(cur.sp), "R5", "ring_sp", ring_sp, cur.sp);
        chk(ring_read == (cur.kind == 3), "R7", "ring_read", ring_read, cur.kind == 3);
      end
      chk(tag_status == m_st, "R6", "tag_status", tag_status, m_st);
      chk(irq == (m_st != 0), "R9", "irq", irq, m_st != 0);
      if (tag_status[5]) seen5 = 1;
    end
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  // transfer engine responder
  int dwait = -1;
  always begin
    @(posedge clk); #2;
    dma_done = 0;
    if (dwait == 0) begin dma_done = 1; dwait = -1; end
    else if (dwait > 0) dwait--;
    if (dma_start) dwait = DMA_LAT;
  end

  // ring responder
  int await_n = -1, asp = 0;
  always begin
    @(posedge clk); #2;
    ring_ack = 0; credit_auto = 0;
    if (await_n == 0) begin
      ring_ack = 1;
      if (auto_cr) credit_auto[asp] = 1;
      await_n = -1;
    end else if (await_n > 0) await_n--;
    if (ring_valid) begin await_n = ACK_LAT; asp = int'(ring_sp); end
  end

  // I/O handler
  int iocnt = 0;
  always begin
    @(posedge clk); #2;
    iocnt++;
    io_ready = io_gate && (iocnt % 3 != 1);
  end

  task automatic push(input int kind, input int sp, input int tag);
    bit acc;
    @(posedge clk); #2;
    req_valid = 1; req_kind = 2'(kind); req_sp = SP_W'(sp);
    req_tag = TAG_W'(tag); req_addr = ADDR_W'(16'h100 + tag); req_cmd = 32'hC0DE0000 + 32'(tag);
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #2;
    end while (!acc);
    req_valid = 0;
  endtask

  task automatic clear_tag(input int tag);
    @(posedge clk); #2;
    clr_valid = 1; clr_tag = TAG_W'(tag);
    @(posedge clk); #2;
    clr_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); n++; end
    while (!(m_ph == 0 && mq.size() == 0) && n < 2000);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    // R11: reset state
    chk(!io_valid && !dma_start && !ring_valid, "R11", "idle outputs", {io_valid, dma_start, ring_valid}, 0);
    chk(tag_status == 0 && !irq, "R11", "status clear", tag_status, 0);
    chk(req_ready == 1, "R11", "req_ready", req_ready, 1);
    chk_on = 1;

    // mixed traffic with credits returned on ack
    push(0, 0, 7); push(1, 0, 6); push(2, 0, 0); push(3, 1, 1); push(1, 2, 6);
    wait_idle();
    chk(tag_status == 8'h03, "R6", "write+read done", tag_status, 8'h03);
    chk(irq == 1, "R9", "irq raised", irq, 1);
    clear_tag(0);
    @(negedge clk);
    chk(tag_status == 8'h02, "R8", "clear tag0", tag_status, 8'h02);
    clear_tag(1);
    @(negedge clk);
    chk(irq == 0, "R9", "irq low after clears", irq, 0);

    // credit stall blocks queue
    auto_cr = 0;
    push(2, 2, 2); push(2, 2, 3); push(2, 2, 4); push(0, 0, 6);
    repeat (60) @(negedge clk);
    chk(tag_status == 8'h0C, "R4", "third dispatch held", tag_status, 8'h0C);
    chk(io_valid == 0, "R10", "io behind stall", io_valid, 0);
    @(posedge clk); #2 credit_man = 4'b0100;
    @(posedge clk); #2 credit_man = 0;
    wait_idle();
    chk(tag_status == 8'h1C, "R5", "returned credit used", tag_status, 8'h1C);
    auto_cr = 1;
    clear_tag(2); clear_tag(3); clear_tag(4);

    // queue full while I/O handler refuses
    io_gate = 0;
    for (int i = 0; i < DEPTH + 1; i++) push(i % 2, 0, i);
    @(negedge clk);
    chk(req_ready == 0, "R1", "full queue", req_ready, 0);
    io_gate = 1;
    wait_idle();

    // set and clear of the same tag collide
    @(posedge clk); #2 clr_valid = 1; clr_tag = 3'd5;
    push(2, 3, 5);
    wait_idle();
    @(posedge clk); #2 clr_valid = 0;
    @(negedge clk);
    chk(seen5 == 1, "R8", "set wins over clear", seen5, 1);
    chk(tag_status[5] == 0, "R8", "held clear removes bit", tag_status[5], 0);

    // compute read with stalled credit
    auto_cr = 0;
    push(3, 3, 6); push(3, 3, 7); push(3, 3, 1);
    repeat (40) @(negedge clk);
    chk(tag_status == 8'hC0, "R7", "reads done before stall", tag_status, 8'hC0);
    @(posedge clk); #2 credit_man = 4'b1000;
    @(posedge clk); #2 credit_man = 0;
    wait_idle();
    chk(tag_status == 8'hC2, "R7", "last read done", tag_status, 8'hC2);
    finish_run();
  end
endmodule